// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the command logic of a small parallel NOR flash with an 8-bit data path. The host drives address, data, a write strobe, a chip enable and an output enable as plain asynchronous-style pins. The block brings all of them into its own clock domain and treats the end of each write as one command cycle. It decodes two unlock sequences. One enters identifier mode, where reads return fixed code bytes. The other starts a timed internal chip erase.

The erase runs in two phases. A pre-program phase first clears every array byte to zero, and an erase phase then sets every byte to FFh. While either phase runs, or while a timeout is pending, any read returns a status byte instead of array data. The host polls that byte to follow progress: a done bit, a bit that flips on every read, and a timeout flag. The array is a small register file. After reset it holds a computed pattern, so the effect of an erase can be seen at the pins.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array read mode. A read returns array byte `addr_i[IDX-1:0]`, where IDX = log2(DEPTH). Byte i holds (29*i + 7) mod 256, and the higher address bits are ignored.
- R2: A write cycle is the interval in which `we_n_i` and `ce_n_i` are both low. It is accepted once, when the first of the two rises, with the address and data that were held during the strobe.
- R3: Six writes start a chip erase, in this order: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h.
- R4: While the engine is busy, every read returns a status byte. Bit 7 is 0, bit 6 inverts after each completed read, bit 5 is the timeout flag, and bits 4..0 are 0.
- R5: Without a forced timeout, the erase ends about PROG_CYC+ERASE_CYC clocks after it starts. The block then returns to read mode, every array byte reads FFh, and bit 6 no longer changes between reads.
- R6: The writes AAh@555h, 55h@2AAh, 90h@555h enter identifier mode. In this mode a read returns C2h when `addr_i[1:0]`=00, 4Fh when it is 01, and 00h when it is 10 or 11. The higher address bits have no effect.
- R7: A write that does not match the next expected step returns the decoder to read mode. It starts nothing, and the following writes are decoded from the first step again.
- R8: Writing F0h in identifier mode returns the block to array reads. Writing F0h in read mode leaves array reads unchanged.
- R9: Writes made while the erase phases run, including F0h, are ignored, and the status byte keeps bit 7 at 0.
- R10: While `force_tmo_i` is high, the erase phase does not complete. After LIMIT_CYC erase-phase clocks, status bit 5 reads 1 and bit 7 stays 0 until an F0h write arrives. The block then returns to read mode, and the array reads all 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 11 | Bus address |
| data_i | input | 8 | Write data |
| we_n_i | input | 1 | Write strobe, active low |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low; a read ends when it or ce_n_i rises |
| force_tmo_i | input | 1 | Test input that stops the erase phase from completing |
| data_o | output | 8 | Read data: array byte, identifier byte or status byte |

## Verification
The bench sweeps the whole small array before the erase, after a clean erase and after a timed-out erase. It reads all four identifier addresses, with and without high address bits set. The sequence tests aim at near misses: a repeated unlock write and a wrong fifth write. A decoder that stayed in a partial state would then accept a later fragment and enter identifier mode or start an erase. During the erase the bench compares bit 6 of successive polls and then checks the done time against the phase lengths. A toggle that does not advance on each read, or a phase counter off by a large margin, shows up there. It also writes F0h during a running erase, which a decoder that does not ignore writes while busy would act on. Finally it forces a timeout and checks that the flag persists until F0h and that the pre-program zeros remain.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int ADDR_W = 11;

    localparam logic [ADDR_W-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [7:0] KEY_DATA_A   = 8'hAA;
    localparam logic [7:0] KEY_DATA_B   = 8'h55;
    localparam logic [7:0] OP_ARM       = 8'h80;
    localparam logic [7:0] OP_WIPE      = 8'h10;
    localparam logic [7:0] OP_IDENT     = 8'h90;
    localparam logic [7:0] OP_ABORT     = 8'hF0;
    localparam logic [7:0] CODE_MAKER   = 8'hC2;
    localparam logic [7:0] CODE_PART    = 8'h4F;
    localparam logic [7:0] CODE_GUARD   = 8'h00;

    typedef enum logic [2:0] {
        CS_READ, CS_KEY1, CS_KEY2, CS_ARMED, CS_AKEY1, CS_AKEY2, CS_IDENT, CS_BUSY
    } cmd_state_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_PROG, PH_ERASE, PH_TMO
    } erase_phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } bus_wr_t;

    function automatic logic [7:0] init_byte(input int idx);
        return 8'((idx * 29 + 7) % 256);
    endfunction

    function automatic logic [7:0] status_byte(input logic tgl, input logic tmo);
        return {1'b0, tgl, tmo, 5'b0};
    endfunction

    function automatic logic [7:0] ident_byte(input logic [1:0] sel);
        case (sel)
            2'b00:   return CODE_MAKER;
            2'b01:   return CODE_PART;
            default: return CODE_GUARD;
        endcase
    endfunction

    function automatic logic wr_hit(input bus_wr_t w, input logic [ADDR_W-1:0] a,
                                    input logic [7:0] d);
        return (w.addr == a) && (w.data == d);
    endfunction

endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic              we_n_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    output bus_wr_t           wr_o,
    output logic              wr_stb_o,
    output logic              rd_done_o
);
    // strobe vectors: [2]=oe_n, [1]=ce_n, [0]=we_n
    logic [2:0] stb_s1, stb_s2;
    bus_wr_t    bus_s1, bus_s2, bus_q;
    logic       wr_act, rd_act, wr_act_q, rd_act_q;

    assign wr_act = ~stb_s2[0] & ~stb_s2[1];
    assign rd_act = ~stb_s2[2] & ~stb_s2[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_s1   <= '1;
            stb_s2   <= '1;
            bus_s1   <= '0;
            bus_s2   <= '0;
            bus_q    <= '0;
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
        end else begin
            stb_s1   <= {oe_n_i, ce_n_i, we_n_i};
            stb_s2   <= stb_s1;
            bus_s1   <= '{addr: addr_i, data: data_i};
            bus_s2   <= bus_s1;
            bus_q    <= bus_s2;
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
        end
    end

    assign wr_stb_o  = wr_act_q & ~wr_act;
    assign rd_done_o = rd_act_q & ~rd_act;
    assign wr_o      = bus_q;

    // R2
    wr_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> $past(wr_act));

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_stb_i,
    input  bus_wr_t wr_i,
    input  logic    busy_i,
    output logic    start_o,
    output logic    ident_o
);
    cmd_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        start_o  = 1'b0;
        if (state == CS_BUSY) begin
            if (!busy_i) state_nx = CS_READ;
        end else if (wr_stb_i) begin
            state_nx = CS_READ;
            case (state)
                CS_READ:  if (wr_hit(wr_i, KEY_ADDR_A, KEY_DATA_A)) state_nx = CS_KEY1;
                CS_KEY1:  if (wr_hit(wr_i, KEY_ADDR_B, KEY_DATA_B)) state_nx = CS_KEY2;
                CS_KEY2: begin
                    if (wr_hit(wr_i, KEY_ADDR_A, OP_ARM))        state_nx = CS_ARMED;
                    else if (wr_hit(wr_i, KEY_ADDR_A, OP_IDENT)) state_nx = CS_IDENT;
                end
                CS_ARMED: if (wr_hit(wr_i, KEY_ADDR_A, KEY_DATA_A)) state_nx = CS_AKEY1;
                CS_AKEY1: if (wr_hit(wr_i, KEY_ADDR_B, KEY_DATA_B)) state_nx = CS_AKEY2;
                CS_AKEY2: begin
                    if (wr_hit(wr_i, KEY_ADDR_A, OP_WIPE)) begin
                        state_nx = CS_BUSY;
                        start_o  = 1'b1;
                    end
                end
                default: state_nx = CS_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CS_READ;
        else     state <= state_nx;
    end

    assign ident_o = (state == CS_IDENT);

    // R6
    ident_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ident_o) |-> ($past(state) == CS_KEY2) && $past(wr_stb_i));

    // R9
    busy_tracked_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> state == CS_BUSY);

endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
    import flash_cmd_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 256,
    parameter int LIMIT_CYC = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     force_tmo_i,
    input  logic                     clr_i,
    input  logic                     rd_done_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic                     busy_o,
    output logic [7:0]               status_o,
    output logic [7:0]               arr_byte_o
);
    localparam int CNT_W = $clog2(LIMIT_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] LIMIT_LAST = CNT_W'(LIMIT_CYC - 1);

    erase_phase_e     phase;
    logic [CNT_W-1:0] cnt;
    logic             tgl, tmo;
    logic [7:0]       mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            tmo   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
        end else begin
            case (phase)
                PH_IDLE: if (start_i) begin
                    phase <= PH_PROG;
                    cnt   <= '0;
                    tmo   <= 1'b0;
                end
                PH_PROG: begin
                    if (cnt == PROG_LAST) begin
                        for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
                        cnt   <= '0;
                        phase <= PH_ERASE;
                    end else cnt <= cnt + 1'b1;
                end
                PH_ERASE: begin
                    if (cnt == ERASE_LAST && !force_tmo_i) begin
                        for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
                        phase <= PH_IDLE;
                    end else if (cnt == LIMIT_LAST) begin
                        phase <= PH_TMO;
                        tmo   <= 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                PH_TMO: if (clr_i) begin
                    phase <= PH_IDLE;
                    tmo   <= 1'b0;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        tgl <= 1'b0;
        else if (busy_o && rd_done_i)   tgl <= ~tgl;
    end

    assign busy_o     = (phase != PH_IDLE);
    assign status_o   = status_byte(tgl, tmo);
    assign arr_byte_o = mem[rd_idx_i];

    // R3
    erase_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R5
    erase_fill_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && $past(phase) == PH_ERASE) |-> mem[0] == 8'hFF);

    // R10
    tmo_zeroed_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TMO) |-> mem[0] == 8'h00);

    // R4
    tgl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !$past(busy_o)) |-> $stable(tgl));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 256,
    parameter int LIMIT_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic              we_n_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              force_tmo_i,
    output logic [7:0]        data_o
);
    localparam int IDX_W = $clog2(DEPTH);

    bus_wr_t    wr;
    logic       wr_stb, rd_done, start, ident, busy, clr;
    logic [7:0] status, arr_byte;

    flash_bus_sync u_sync (
        .clk(clk), .rst(rst), .addr_i(addr_i), .data_i(data_i),
        .we_n_i(we_n_i), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
        .wr_o(wr), .wr_stb_o(wr_stb), .rd_done_o(rd_done)
    );

    flash_cmd_fsm u_fsm (
        .clk(clk), .rst(rst), .wr_stb_i(wr_stb), .wr_i(wr), .busy_i(busy),
        .start_o(start), .ident_o(ident)
    );

    assign clr = wr_stb && (wr.data == OP_ABORT);

    flash_erase_engine #(
        .DEPTH(DEPTH), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .LIMIT_CYC(LIMIT_CYC)
    ) u_engine (
        .clk(clk), .rst(rst), .start_i(start), .force_tmo_i(force_tmo_i),
        .clr_i(clr), .rd_done_i(rd_done), .rd_idx_i(addr_i[IDX_W-1:0]),
        .busy_o(busy), .status_o(status), .arr_byte_o(arr_byte)
    );

    always_comb begin
        if (busy)       data_o = status;
        else if (ident) data_o = ident_byte(addr_i[1:0]);
        else            data_o = arr_byte;
    end

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int PROG  = 20;
    localparam int ERASE = 40;
    localparam int LIMIT = 90;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        we_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, force_tmo = 1'b0;
    logic [7:0]  rdata;

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_cmd_ctrl #(.DEPTH(DEPTH), .PROG_CYC(PROG), .ERASE_CYC(ERASE), .LIMIT_CYC(LIMIT)) dut_i (
        .clk(clk), .rst(rst), .addr_i(addr), .data_i(wdata), .we_n_i(we_n),
        .ce_n_i(ce_n), .oe_n_i(oe_n), .force_tmo_i(force_tmo), .data_o(rdata)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29 + 7) % 256);
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d, input bit ce_first = 0);
        @(negedge clk);
        addr = a; wdata = d; we_n = 1'b0; ce_n = 1'b0;
        repeat (2) @(negedge clk);
        if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; oe_n = 1'b0; ce_n = 1'b0;
        repeat (2) @(negedge clk);
        d = rdata;
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic unlock();
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
    endtask

    task automatic erase_cmd();
        unlock();
        wr(11'h555, 8'h80);
        unlock();
        wr(11'h555, 8'h10);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        wait (cyc >= 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
    end

    initial begin
        logic [7:0] d, d2;
        int t0, polls, flips_bad;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset pattern, high address bits ignored
        for (int i = 0; i < DEPTH; i++) begin
            rd(11'(i + ((i % 2) ? 11'h400 : 11'h0)), d);
            check("R1", d, pat(i));
        end

        // R6 with R2: identifier mode, last write closed by chip enable first
        unlock();
        wr(11'h555, 8'h90, 1);
        rd(11'h000, d); check("R6", d, 8'hC2);
        rd(11'h001, d); check("R6", d, 8'h4F);
        rd(11'h002, d); check("R6", d, 8'h00);
        rd(11'h003, d); check("R6", d, 8'h00);
        rd(11'h104, d); check("R6", d, 8'hC2);
        rd(11'h7F1, d); check("R6", d, 8'h4F);
        // R8: abort in identifier mode
        wr(11'h123, 8'hF0);
        rd(11'h000, d); check("R8", d, pat(0));
        // R8: abort in read mode harmless
        wr(11'h555, 8'hF0);
        rd(11'h005, d); check("R8", d, pat(5));

        // R7: repeated first unlock breaks; tail fragments ignored
        wr(11'h555, 8'hAA);
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        wr(11'h555, 8'h90);
        rd(11'h000, d); check("R7", d, pat(0));
        // R7: wrong fifth write of the erase sequence
        unlock();
        wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h00);
        wr(11'h555, 8'h10);
        rd(11'h001, d); check("R7", d, pat(1));

        // R3/R4/R5/R9: clean erase
        erase_cmd();
        t0 = cyc;
        rd(11'h003, d);
        check("R4", d & 8'hBF, 8'h00);
        rd(11'h003, d2);
        check("R4", (d ^ d2) & 8'h40, 8'h40);
        wr(11'h555, 8'hF0);
        rd(11'h003, d);
        check("R9", d & 8'h80, 8'h00);
        d2 = d;
        polls = 0; flips_bad = 0;
        while (polls < 60) begin
            rd(11'h003, d);
            polls++;
            if (d[7]) break;
            if (((d ^ d2) & 8'h40) == 0) flips_bad++;
            d2 = d;
        end
        check("R4", 8'(flips_bad), 8'h00);
        check("R5", 8'(d[7]), 8'h01);
        check("R5", 8'((cyc - t0) >= PROG + ERASE - 8 && (cyc - t0) <= PROG + ERASE + 16), 8'h01);
        rd(11'h003, d); rd(11'h003, d2);
        check("R5", d2, d);
        for (int i = 0; i < DEPTH; i++) begin
            rd(11'(i), d);
            check("R5", d, 8'hFF);
        end

        // R10: forced timeout
        force_tmo = 1'b1;
        erase_cmd();
        t0 = cyc;
        polls = 0;
        d = 8'h00;
        while (polls < 60 && !d[5]) begin
            rd(11'h000, d);
            polls++;
        end
        check("R10", d & 8'hA0, 8'h20);
        check("R10", 8'((cyc - t0) >= PROG + LIMIT - 8), 8'h01);
        repeat (20) @(negedge clk);
        rd(11'h000, d);
        check("R10", d & 8'hA0, 8'h20);
        wr(11'h555, 8'hF0);
        force_tmo = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            rd(11'(i), d);
            check("R10", d, 8'h00);
        end

        summary();
    end
endmodule